// File: doc/BRIEF.md
# Clear-on-Read Conversion Result Bank

This block holds the results of an analog-to-digital converter. Each result is 16 bits wide, and there is one register per result. Registers `0` to `NUM_CH-1` hold the per-channel results. Four further registers follow them and hold the special results:

| Index | Result |
|---|---|
| `NUM_CH` | self-test |
| `NUM_CH+1` | temperature |
| `NUM_CH+2` | internal reference |
| `NUM_CH+3` | double-trigger |

The converter writes a register with a one-cycle completion strobe that carries the register index and the data. The processor, the DMA engine and the transfer engine reach the bank through one shared read port. A read is a one-cycle request strobe with an address, and the data comes back one cycle later.

A single control bit chooses what a read does:
- **Bit clear:** a read leaves the register untouched, so old data stays readable.
- **Bit set:** a read returns the stored value and zeroes the register on the same clock edge.

With the bit set, a conversion result that never arrives is easy to spot. A later read returns zero instead of repeating the previous result.

Top module: `aclr_bank`

## Requirements
- R1: After reset every result register reads 0000h, the clear-enable bit is 0, and `rd_valid` and `rd_data` are 0.
- R2: A `cv_valid` strobe with `cv_idx` below `NUM_CH+4` stores `cv_data` into that register on the same edge. An index at or above `NUM_CH+4` changes no register.
- R3: A `rd_req` sampled on an edge makes `rd_valid` 1 for the next cycle. In that cycle `rd_data` carries the value the register held before the edge. An address at or above `NUM_CH+4` returns 0000h. Without `rd_req`, `rd_valid` and `rd_data` are 0 in the next cycle.
- R4: With the clear-enable bit at 1, a read of a channel register sets that register to 0000h on the edge that captures the read data.
- R5: With the clear-enable bit at 0, a read changes no register.
- R6: A write and a read that hit the same register on the same edge keep the written value stored. The read returns the value from before that edge, whatever the clear-enable setting.
- R7: Clearing on read applies in the same way to the four special registers at indices `NUM_CH` to `NUM_CH+3`.
- R8: A register that had a clearing read and no write since returns 0000h on a later read. With clearing disabled, the last written value is returned again.
- R9: `ctl_we` loads `ctl_wdata` into the clear-enable bit on the edge. A read on that same edge uses the previous setting of the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases after two clock edges |
| ctl_we | input | 1 | Write strobe for the clear-enable bit |
| ctl_wdata | input | 1 | New value of the clear-enable bit |
| cv_valid | input | 1 | Conversion-complete strobe |
| cv_idx | input | AW | Index of the result register being written |
| cv_data | input | DW | Conversion result |
| rd_req | input | 1 | Read strobe from any bus master |
| rd_addr | input | AW | Register index to read |
| rd_valid | output | 1 | Read data is present this cycle |
| rd_data | output | DW | Read data; zero when `rd_valid` is low |

## Verification
Some internal faults are only visible through later reads:
- **Clear fires without the enable:** the second read of a register shows a zero where the old value was expected.
- **Clear fails to fire with the enable set:** the second read shows the stale value where zero was expected.
- **Wrong priority in a read/write collision:** the read issued one cycle after the collision shows zero instead of the new value.

In every case the fault shows up on the read that follows the faulty edge, one cycle after its request. Each register is written, then read three times, under both settings of the control bit. This covers out-of-range indices and the four special registers, so a fault in any single register is seen within a few cycles.

// File: rtl/aclr_pkg.sv
package aclr_pkg;

  // Special result registers, placed directly after the channel registers.
  typedef enum logic [1:0] {
    SPEC_SELFTEST = 2'd0,
    SPEC_TEMP     = 2'd1,
    SPEC_VREF     = 2'd2,
    SPEC_DBLTRIG  = 2'd3
  } spec_e;

  localparam int unsigned NUM_SPEC = 4;

  function automatic int unsigned spec_index(input int unsigned nch, input spec_e kind);
    return nch + int'(kind);
  endfunction

endpackage

// File: rtl/aclr_rst_sync.sv
module aclr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign srst_n = stage1_q;

endmodule

// File: rtl/aclr_decode.sv
module aclr_decode #(
  parameter int unsigned NREG = 12,
  parameter int unsigned AW   = 4
) (
  input  logic            valid,
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] hit
);

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = valid && (addr == AW'(i));
  end

endmodule

// File: rtl/aclr_cell.sv
module aclr_cell #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wdata,
  input  logic          rd_hit,
  input  logic          clr_en,
  output logic [DW-1:0] q
);

  logic          q_en;
  logic [DW-1:0] q_nxt;

  // Next state: a write outranks a clearing read on the same edge.
  always_comb begin
    q_en  = 1'b0;
    q_nxt = q;
    if (wr_hit) begin
      q_en  = 1'b1;
      q_nxt = wdata;
    end else if (rd_hit && clr_en) begin
      q_en  = 1'b1;
      q_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_nxt;
    end
  end

  assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> q == $past(wdata));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && clr_en && !wr_hit) |=> q == '0);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !(rd_hit && clr_en)) |=> q == $past(q));

  assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && rd_hit && clr_en) |=> q == $past(wdata));

endmodule

// File: rtl/aclr_rdmux.sv
module aclr_rdmux #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 12,
  parameter int unsigned AW   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_req,
  input  logic [AW-1:0]      rd_addr,
  input  logic [NREG*DW-1:0] regs_flat,
  output logic               rd_valid,
  output logic [DW-1:0]      rd_data
);

  logic [DW-1:0] sel;
  logic [DW-1:0] data_nxt;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr == AW'(i)) begin
        sel = regs_flat[i*DW +: DW];
      end
    end
    data_nxt = rd_req ? sel : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= data_nxt;
    end
  end

  assert_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (!rd_valid && rd_data == '0));

endmodule

// File: rtl/aclr_bank.sv
module aclr_bank
  import aclr_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DW     = 16,
  localparam int unsigned NREG  = NUM_CH + NUM_SPEC,
  localparam int unsigned AW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          ctl_wdata,
  input  logic          cv_valid,
  input  logic [AW-1:0] cv_idx,
  input  logic [DW-1:0] cv_data,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  localparam int unsigned LAST_SPEC = spec_index(NUM_CH, SPEC_DBLTRIG);

  logic               srst_n;
  logic               clr_en_q;
  logic               clr_en_nxt;
  logic [NREG-1:0]    wr_hit;
  logic [NREG-1:0]    rd_hit;
  logic [NREG*DW-1:0] regs_flat;

  aclr_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // Clear-enable control bit.
  always_comb begin
    clr_en_nxt = clr_en_q;
    if (ctl_we) begin
      clr_en_nxt = ctl_wdata;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      clr_en_q <= 1'b0;
    end else if (ctl_we) begin
      clr_en_q <= clr_en_nxt;
    end
  end

  aclr_decode #(.NREG(NREG), .AW(AW)) u_wr_dec (
    .valid (cv_valid),
    .addr  (cv_idx),
    .hit   (wr_hit)
  );

  aclr_decode #(.NREG(NREG), .AW(AW)) u_rd_dec (
    .valid (rd_req),
    .addr  (rd_addr),
    .hit   (rd_hit)
  );

  // Channel and special registers share one cell type; every class clears alike.
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    aclr_cell #(.DW(DW)) u_cell (
      .clk    (clk),
      .rst_n  (srst_n),
      .wr_hit (wr_hit[i]),
      .wdata  (cv_data),
      .rd_hit (rd_hit[i]),
      .clr_en (clr_en_q),
      .q      (regs_flat[i*DW +: DW])
    );
  end

  aclr_rdmux #(.DW(DW), .NREG(NREG), .AW(AW)) u_rdmux (
    .clk       (clk),
    .rst_n     (srst_n),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .regs_flat (regs_flat),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  assert_ctl_load_R9: assert property (@(posedge clk) disable iff (!srst_n)
    ctl_we |=> clr_en_q == $past(ctl_wdata));

  assert_ctl_hold_R9: assert property (@(posedge clk) disable iff (!srst_n)
    !ctl_we |=> $stable(clr_en_q));

  // The last special register must sit inside the addressable range (R7).
  initial begin
    assert_spec_range_R7: assert (LAST_SPEC < (1 << AW));
  end

endmodule

// File: tb/aclr_bank_test.sv
module aclr_bank_test;

  localparam int unsigned NUM_CH = 8;
  localparam int unsigned DW     = 16;
  localparam int unsigned NREG   = NUM_CH + 4;
  localparam int unsigned AW     = $clog2(NREG);
  localparam int unsigned NADDR  = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          ctl_we;
  logic          ctl_wdata;
  logic          cv_valid;
  logic [AW-1:0] cv_idx;
  logic [DW-1:0] cv_data;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  aclr_bank #(.NUM_CH(NUM_CH), .DW(DW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .cv_valid  (cv_valid),
    .cv_idx    (cv_idx),
    .cv_data   (cv_data),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int            total;
  int            bad;
  logic [DW-1:0] mdl [NREG];
  logic          mdl_en;
  logic [DW-1:0] exp_rd;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Drive one cycle from a negedge, wait for the next negedge, update the model.
  task automatic cyc(input logic we, input logic wv,
                     input logic cvv, input int ci, input logic [DW-1:0] cd,
                     input logic rr, input int ra);
    ctl_we    = we;
    ctl_wdata = wv;
    cv_valid  = cvv;
    cv_idx    = AW'(ci);
    cv_data   = cd;
    rd_req    = rr;
    rd_addr   = AW'(ra);
    exp_rd    = (rr && ra < int'(NREG)) ? mdl[ra] : '0;
    @(negedge clk);
    if (rr && ra < int'(NREG) && mdl_en && !(cvv && ci == ra)) mdl[ra] = '0;
    if (cvv && ci < int'(NREG)) mdl[ci] = cd;
    if (we) mdl_en = wv;
    ctl_we   = 1'b0;
    cv_valid = 1'b0;
    rd_req   = 1'b0;
  endtask

  task automatic do_read(input string req, input int a);
    cyc(1'b0, 1'b0, 1'b0, 0, '0, 1'b1, a);
    chk(req, "rd_valid", DW'(rd_valid), DW'(1));
    chk(req, $sformatf("rd_data[%0d]", a), rd_data, exp_rd);
  endtask

  task automatic do_write(input int i, input logic [DW-1:0] d);
    cyc(1'b0, 1'b0, 1'b1, i, d, 1'b0, 0);
    chk("R3", "idle rd_valid", DW'(rd_valid), '0);
    chk("R3", "idle rd_data", rd_data, '0);
  endtask

  task automatic set_en(input logic v);
    cyc(1'b1, v, 1'b0, 0, '0, 1'b0, 0);
  endtask

  function automatic logic [DW-1:0] pat(input int r, input int en);
    return DW'((r + 1) * 'h0111 + en * 'h0800);
  endfunction

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
    $finish;
  end

  initial begin
    total = 0;
    bad   = 0;
    rst_n = 1'b0;
    ctl_we = 1'b0; ctl_wdata = 1'b0; cv_valid = 1'b0; cv_idx = '0;
    cv_data = '0; rd_req = 1'b0; rd_addr = '0;
    mdl_en = 1'b0;
    for (int i = 0; i < int'(NREG); i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "rd_valid in reset", DW'(rd_valid), '0);
    chk("R1", "rd_data in reset", rd_data, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: every register reads zero after reset; clearing starts disabled.
    for (int a = 0; a < int'(NREG); a++) do_read("R1", a);
    for (int a = 0; a < int'(NREG); a++) do_read("R1", a);

    // Sweep both settings over every index, including out-of-range ones.
    for (int en = 0; en < 2; en++) begin
      set_en(en[0]);
      for (int r = 0; r < int'(NADDR); r++) do_write(r, pat(r, en));
      for (int r = 0; r < int'(NADDR); r++) begin
        string lbl;
        if (r >= int'(NREG)) lbl = "R3";
        else if (en == 0) lbl = "R5";
        else if (r >= int'(NUM_CH)) lbl = "R7";
        else lbl = "R4";
        do_read((r >= int'(NREG)) ? "R3" : "R2", r);
        do_read(lbl, r);
        do_read("R8", r);
      end
    end

    // R6: a write and a read hit the same register on one edge.
    for (int en = 0; en < 2; en++) begin
      set_en(en[0]);
      do_write(3, 16'hA5A5);
      cyc(1'b0, 1'b0, 1'b1, 3, 16'h5A5A, 1'b1, 3);
      chk("R6", "collision rd_data", rd_data, 16'hA5A5);
      do_read("R6", 3);
      do_write(NUM_CH + 1, 16'h1357);
      cyc(1'b0, 1'b0, 1'b1, NUM_CH + 1, 16'h2468, 1'b1, NUM_CH + 1);
      chk("R6", "special collision rd_data", rd_data, 16'h1357);
      do_read("R6", NUM_CH + 1);
    end

    // R9: enabling clearing on the same edge as a read uses the old setting.
    set_en(1'b0);
    do_write(5, 16'hC0DE);
    cyc(1'b1, 1'b1, 1'b0, 0, '0, 1'b1, 5);
    chk("R9", "read with ctl write", rd_data, 16'hC0DE);
    do_read("R9", 5);
    do_read("R9", 5);
    // Disabling on the same edge as a read still clears.
    do_write(6, 16'hBEEF);
    cyc(1'b1, 1'b0, 1'b0, 0, '0, 1'b1, 6);
    chk("R9", "read with ctl clear", rd_data, 16'hBEEF);
    do_read("R9", 6);

    // R3: back-to-back reads, then an idle cycle.
    do_write(0, 16'h0F0F);
    do_write(NUM_CH + 3, 16'hF0F0);
    do_read("R3", 0);
    do_read("R3", NUM_CH + 3);
    cyc(1'b0, 1'b0, 1'b0, 0, '0, 1'b0, 0);
    chk("R3", "idle rd_valid", DW'(rd_valid), '0);
    chk("R3", "idle rd_data", rd_data, '0);

    summary();
    $finish;
  end

endmodule